// File: doc/BRIEF.md
# Posit Number Multiplier

This block multiplies two posit numbers of a configurable word size and a configurable exponent-field width. Each operand is split into sign, regime run, exponent bits and fraction. The two significands, each with an implicit leading one, are multiplied. The two scales are added. The product is then packed back into a posit word of the same size and rounded to nearest, with ties going to the even bit pattern.

Results never overflow and never underflow. A product larger than the biggest positive value clamps to that value. A nonzero product smaller than the smallest positive value comes out as that smallest value. The sign is kept in both cases. The all-zero word is zero. The word with only its top bit set is the one unsigned infinity.

A separate flag marks the one undefined case: infinity times zero, in either operand order. The block accepts a pair of operands whenever the input strobe is high. It returns the registered product one clock later.

Top module: `posit_mul`

## Requirements
- R1: `out_vld` equals the value `in_vld` had one clock earlier. `out_p` and `out_nan` load only on a clock where `in_vld` is high, and they keep their value across cycles where it is low.
- R2: While `rst` is high at a rising clock edge, `out_vld`, `out_p` and `out_nan` all become 0, whatever the inputs are.
- R3: Encoding of a word:
  - The all-zero word is zero. The word `1` followed by zeros is infinity.
  - A word whose top bit is 1 is negative, and its magnitude is the two's-complement negation of the whole word.
  - After the sign comes a run of equal bits, closed by the opposite bit or by the end of the word. A run of k ones means regime k−1, and a run of k zeros means regime −k.
  - The run is followed by ES exponent bits and then fraction bits. Missing bits count as 0.
  - The value is 2^(regime·2^ES + exponent) · (1 + fraction).
  - With the defaults, 1.0 is 0x40, 1.5 is 0x48 and 2.0 is 0x50.
- R4: If one operand is zero and the other is infinity, `out_nan` is 1 and `out_p` is the infinity word. In every other case `out_nan` is 0.
- R5: If either operand is infinity and neither is zero, the result is the infinity word.
- R6: If either operand is zero and neither is infinity, the result is zero.
- R7: A product whose magnitude is at least the largest positive value gives that value, 0 followed by ones (0x7F by default), with the product's sign. The result is never the infinity word.
- R8: A nonzero product whose magnitude is at most the smallest positive value gives that value, zeros followed by a final 1 (0x01 by default), with the product's sign. The result is never zero.
- R9: Rounding acts on the bit string. The first bit that is dropped is the guard, and the OR of all bits after it is the sticky. The kept word is incremented when guard is 1 and either sticky or the kept lsb is 1. With the defaults, 0x41×0x48 gives 0x4A and 0x43×0x48 gives 0x4C.
- R10: The sign of a finite nonzero result is the XOR of the operand signs. Negating one operand negates the result word (0xBF×0x48 gives 0xB6).
- R11: At the defaults (8-bit words, ES=1), every operand pair gives the posit whose bit-string rounding of the exact real product is correct. The midpoint between neighbours lo and lo+1 is the value of the 9-bit word {lo,1}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand pair is valid this cycle |
| in_a | input | NBITS | First operand posit word |
| in_b | input | NBITS | Second operand posit word |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_p | output | NBITS | Rounded posit product |
| out_nan | output | 1 | Product undefined (zero times infinity) |

## Verification
The hardest cases to reach are the exact round-half ties, and rounding near the ends of the range, where exponent bits drop off the word and the midpoint between neighbours becomes geometric rather than linear. Random operands hit an exact tie only rarely. So the stimulus sweeps all 65,536 operand pairs at the default width, with random idle cycles mixed in, and compares each one against a real-valued model that places midpoints by decoding a word one bit wider. Directed pairs also aim at the two tie directions, at saturation past the largest value, at clamping below the smallest value, and at the special-value combinations.

// File: rtl/posit_pkg.sv
package posit_pkg;

    typedef enum logic [1:0] {
        PC_ZERO = 2'd0,
        PC_INF  = 2'd1,
        PC_NUM  = 2'd2
    } pcls_e;

    // Width of a signed scale able to hold the sum of two operand scales
    // plus the normalisation carry.
    function automatic int scale_width(input int nbits, input int es);
        return $clog2(nbits) + es + 3;
    endfunction

    // Round-to-nearest-even increment decision.
    function automatic logic rne_up(input logic lsb, input logic guard, input logic sticky);
        return guard & (sticky | lsb);
    endfunction

endpackage

// File: rtl/posit_decode.sv
module posit_decode
    import posit_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int ES    = 1,
    parameter int SCW   = scale_width(NBITS, ES)
) (
    input  logic [NBITS-1:0]      word,
    output pcls_e                 cls,
    output logic                  neg,
    output logic signed [SCW-1:0] scale,
    output logic [NBITS-1:0]      sig
);
    localparam int BW = NBITS - 1;

    always_comb begin
        logic [BW-1:0] body;
        logic [BW-1:0] rest;
        logic [BW-1:0] frac_v;
        logic [BW-1:0] expo;
        logic          lead;
        logic          stop;
        int            run;
        int            regime;

        neg    = word[NBITS-1];
        body   = neg ? (~word[BW-1:0] + 1'b1) : word[BW-1:0];
        lead   = body[BW-1];
        run    = 0;
        stop   = 1'b0;
        for (int i = BW - 1; i >= 0; i--) begin
            if (!stop) begin
                if (body[i] == lead) run = run + 1;
                else                 stop = 1'b1;
            end
        end
        rest   = (run + 1 >= BW) ? '0 : (body << (run + 1));
        expo   = rest >> (BW - ES);
        frac_v = rest << ES;
        regime = lead ? (run - 1) : -run;
        scale  = SCW'(regime * (2 ** ES) + int'(expo));
        sig    = {1'b1, frac_v};

        if (word == '0)                           cls = PC_ZERO;
        else if (word == {1'b1, {BW{1'b0}}})      cls = PC_INF;
        else                                      cls = PC_NUM;
    end

endmodule

// File: rtl/posit_encode.sv
module posit_encode
    import posit_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int ES    = 1,
    parameter int SCW   = scale_width(NBITS, ES),
    parameter int FW    = 2 * NBITS - 1
) (
    input  logic                  neg,
    input  logic signed [SCW-1:0] scale,
    input  logic [FW-1:0]         frac,
    output logic [NBITS-1:0]      word
);
    localparam int BW = NBITS - 1;
    localparam int TW = ES + FW;
    localparam int LW = BW + TW;

    always_comb begin
        logic [BW-1:0]    regv;
        logic [TW-1:0]    ef;
        logic [LW-1:0]    longw;
        logic [BW-1:0]    kept;
        logic             guard;
        logic             sticky;
        logic [NBITS-1:0] magn;
        int               s;
        int               r;
        int               e;
        int               rl;

        s      = int'(scale);
        r      = s >>> ES;
        e      = s - r * (2 ** ES);
        regv   = '0;
        rl     = 1;
        ef     = '0;
        longw  = '0;
        kept   = '0;
        guard  = 1'b0;
        sticky = 1'b0;

        if (r >= NBITS - 2) begin
            magn = {1'b0, {BW{1'b1}}};
        end else if (r < -(NBITS - 2)) begin
            magn = NBITS'(1);
        end else begin
            if (r >= 0) begin
                regv = ~({BW{1'b1}} >> (r + 1));
                rl   = r + 2;
            end else begin
                regv = BW'(1) << (BW - 1 + r);
                rl   = 1 - r;
            end
            ef     = TW'(frac) | (TW'(e) << FW);
            longw  = {regv, TW'(0)} | (LW'(ef) << (BW - rl));
            kept   = longw[LW-1 -: BW];
            guard  = longw[TW-1];
            sticky = |longw[TW-2:0];
            magn   = {1'b0, kept + BW'(rne_up(kept[0], guard, sticky))};
        end

        word = neg ? (~magn + 1'b1) : magn;
    end

endmodule

// File: rtl/posit_mul.sv
module posit_mul
    import posit_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int ES    = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [NBITS-1:0] in_a,
    input  logic [NBITS-1:0] in_b,
    output logic             out_vld,
    output logic [NBITS-1:0] out_p,
    output logic             out_nan
);
    localparam int SCW = scale_width(NBITS, ES);
    localparam int PW  = 2 * NBITS;
    localparam int FW  = PW - 1;
    localparam logic [NBITS-1:0] INF_W = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0]      opw [2];
    pcls_e                 cls [2];
    logic                  sgn [2];
    logic signed [SCW-1:0] scl [2];
    logic [NBITS-1:0]      sig [2];

    assign opw[0] = in_a;
    assign opw[1] = in_b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_op
        posit_decode #(.NBITS(NBITS), .ES(ES), .SCW(SCW)) u_dec (
            .word  (opw[gi]),
            .cls   (cls[gi]),
            .neg   (sgn[gi]),
            .scale (scl[gi]),
            .sig   (sig[gi])
        );
    end

    logic [PW-1:0]         prod;
    logic                  carry;
    logic [FW-1:0]         pfrac;
    logic signed [SCW-1:0] pscale;
    logic [NBITS-1:0]      enc_w;

    always_comb begin
        prod   = PW'(sig[0]) * PW'(sig[1]);
        carry  = prod[PW-1];
        pfrac  = carry ? prod[PW-2:0] : {prod[PW-3:0], 1'b0};
        pscale = scl[0] + scl[1] + $signed({{(SCW-1){1'b0}}, carry});
    end

    posit_encode #(.NBITS(NBITS), .ES(ES), .SCW(SCW), .FW(FW)) u_enc (
        .neg   (sgn[0] ^ sgn[1]),
        .scale (pscale),
        .frac  (pfrac),
        .word  (enc_w)
    );

    logic [NBITS-1:0] res_w;
    logic             res_nan;

    always_comb begin
        res_w   = enc_w;
        res_nan = 1'b0;
        if ((cls[0] == PC_ZERO && cls[1] == PC_INF) ||
            (cls[0] == PC_INF  && cls[1] == PC_ZERO)) begin
            res_w   = INF_W;
            res_nan = 1'b1;
        end else if (cls[0] == PC_INF || cls[1] == PC_INF) begin
            res_w = INF_W;
        end else if (cls[0] == PC_ZERO || cls[1] == PC_ZERO) begin
            res_w = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_p   <= '0;
            out_nan <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_p   <= res_w;
                out_nan <= res_nan;
            end
        end
    end

endmodule

// File: rtl/posit_mul_chk.sv
module posit_mul_chk #(
    parameter int NBITS = 8,
    parameter int ES    = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_vld,
    input logic [NBITS-1:0] in_a,
    input logic [NBITS-1:0] in_b,
    input logic             out_vld,
    input logic [NBITS-1:0] out_p,
    input logic             out_nan
);
    localparam logic [NBITS-1:0] INF_W = {1'b1, {(NBITS-1){1'b0}}};

    logic a_z, a_i, b_z, b_i, undef, both_fin;
    assign a_z      = (in_a == '0);
    assign b_z      = (in_b == '0);
    assign a_i      = (in_a == INF_W);
    assign b_i      = (in_b == INF_W);
    assign undef    = (a_z && b_i) || (a_i && b_z);
    assign both_fin = !a_z && !a_i && !b_z && !b_i;

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld); // R1
    AST_VLD_DROPS: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_vld |=> ($stable(out_p) && $stable(out_nan))); // R1
    AST_NAN_RAISE: assert property (@(posedge clk) disable iff (rst) (in_vld && undef) |=> (out_nan && out_p == INF_W)); // R4
    AST_NAN_ONLY: assert property (@(posedge clk) disable iff (rst) (in_vld && !undef) |=> !out_nan); // R4
    AST_INF_PROP: assert property (@(posedge clk) disable iff (rst) (in_vld && (a_i || b_i) && !a_z && !b_z) |=> (out_p == INF_W)); // R5
    AST_ZERO_PROP: assert property (@(posedge clk) disable iff (rst) (in_vld && (a_z || b_z) && !a_i && !b_i) |=> (out_p == '0)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (in_vld && both_fin) |=> (out_p != INF_W)); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) (in_vld && both_fin) |=> (out_p != '0)); // R8
    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst) (in_vld && both_fin) |=> (out_p[NBITS-1] == $past(in_a[NBITS-1] ^ in_b[NBITS-1]))); // R10

endmodule

bind posit_mul posit_mul_chk #(.NBITS(NBITS), .ES(ES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_a    (in_a),
    .in_b    (in_b),
    .out_vld (out_vld),
    .out_p   (out_p),
    .out_nan (out_nan)
);

// File: tb/sim_posit_mul.sv
`timescale 1ns/1ps
module sim_posit_mul;
    localparam int NB = 8;
    localparam int ES = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_vld = 1'b0;
    logic [NB-1:0] in_a = '0;
    logic [NB-1:0] in_b = '0;
    logic          out_vld;
    logic [NB-1:0] out_p;
    logic          out_nan;

    posit_mul #(.NBITS(NB), .ES(ES)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
        .out_vld(out_vld), .out_p(out_p), .out_nan(out_nan)
    );

    always #5 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    real tbl [0:127];

    // pending expectation for the output after the next edge
    bit          pend_v   = 1'b0;
    logic [NB-1:0] pend_p = '0;
    bit          pend_nan = 1'b0;
    string       pend_tag = "R1";
    logic [NB-1:0] held_p = '0;
    bit          held_nan = 1'b0;

    function automatic real pw2(input int k);
        real v = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) v = v * 2.0;
        else        for (int i = 0; i < -k; i++) v = v / 2.0;
        return v;
    endfunction

    // value of a positive nonzero n-bit posit word
    function automatic real pdec(input int unsigned pat, input int n);
        int  run = 0;
        bit  stop = 1'b0;
        int  lead, r, e, pos;
        real f = 0.0;
        real wt = 0.5;
        lead = int'((pat >> (n - 2)) & 1);
        for (int i = n - 2; i >= 0; i--) begin
            if (!stop) begin
                if (int'((pat >> i) & 1) == lead) run++;
                else stop = 1'b1;
            end
        end
        r   = (lead == 1) ? run - 1 : -run;
        pos = n - 2 - run - 1;
        e   = 0;
        for (int j = 0; j < ES; j++) begin
            e = e * 2;
            if (pos >= 0) e = e + int'((pat >> pos) & 1);
            pos--;
        end
        for (int i = pos; i >= 0; i--) begin
            if (((pat >> i) & 1) != 0) f = f + wt;
            wt = wt / 2.0;
        end
        return pw2(r * (1 << ES) + e) * (1.0 + f);
    endfunction

    function automatic int round_mag(input real x);
        int  lo = 1;
        real mid;
        if (x >= tbl[127]) return 127;
        if (x <= tbl[1])   return 1;
        for (int p = 2; p < 128; p++) if (tbl[p] <= x) lo = p;
        if (tbl[lo] == x) return lo;
        mid = pdec((lo << 1) | 1, NB + 1);
        if (x > mid) return lo + 1;
        if (x < mid) return lo;
        return (lo % 2 == 1) ? lo + 1 : lo;
    endfunction

    task automatic model(input logic [NB-1:0] a, input logic [NB-1:0] b,
                         output logic [NB-1:0] p, output bit nan);
        bit az, ai, bz, bi, ng;
        int ma, mb, m;
        az = (a == 8'h00); ai = (a == 8'h80);
        bz = (b == 8'h00); bi = (b == 8'h80);
        nan = 1'b0;
        if ((az && bi) || (ai && bz)) begin p = 8'h80; nan = 1'b1; end
        else if (ai || bi) p = 8'h80;
        else if (az || bz) p = 8'h00;
        else begin
            ng = a[7] ^ b[7];
            ma = a[7] ? (256 - int'(a)) : int'(a);
            mb = b[7] ? (256 - int'(b)) : int'(b);
            m  = round_mag(tbl[ma] * tbl[mb]);
            p  = ng ? NB'((256 - m) % 256) : NB'(m);
        end
    endtask

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // at a falling edge: verify what the previous drive produced
    task automatic verify;
        checks++;
        if (pend_v) begin
            if (out_vld !== 1'b1 || out_p !== pend_p || out_nan !== pend_nan) begin
                errors++;
                $display("FAIL %s: vld/p/nan got %b/%h/%b expected 1/%h/%b",
                         pend_tag, out_vld, out_p, out_nan, pend_p, pend_nan);
            end
            held_p   = pend_p;
            held_nan = pend_nan;
        end else begin
            if (out_vld !== 1'b0 || out_p !== held_p || out_nan !== held_nan) begin
                errors++;
                $display("FAIL R1: idle vld/p/nan got %b/%h/%b expected 0/%h/%b",
                         out_vld, out_p, out_nan, held_p, held_nan);
            end
        end
    endtask

    task automatic apply(input bit v, input logic [NB-1:0] a, input logic [NB-1:0] b,
                         input string tag);
        logic [NB-1:0] ep;
        bit en;
        @(negedge clk);
        verify();
        in_vld = v; in_a = a; in_b = b;
        model(a, b, ep, en);
        pend_v = v; pend_p = ep; pend_nan = en; pend_tag = tag;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        for (int p = 1; p < 128; p++) tbl[p] = pdec(p, NB);
        tbl[0] = 0.0;

        // R2: reset holds outputs at zero even with operands offered
        in_vld = 1'b1; in_a = 8'h40; in_b = 8'h48;
        repeat (3) @(negedge clk);
        checks++;
        if (out_vld !== 1'b0 || out_p !== 8'h00 || out_nan !== 1'b0) begin
            errors++;
            $display("FAIL R2: vld/p/nan got %b/%h/%b expected 0/00/0", out_vld, out_p, out_nan);
        end
        rst = 1'b0; in_vld = 1'b0;
        pend_v = 1'b0; held_p = '0; held_nan = 1'b0;

        apply(1, 8'h40, 8'h40, "R3");   // 1.0 * 1.0
        apply(1, 8'h48, 8'h50, "R3");   // 1.5 * 2.0
        apply(1, 8'h00, 8'h80, "R4");
        apply(1, 8'h80, 8'h00, "R4");
        apply(1, 8'h80, 8'hC3, "R5");
        apply(1, 8'h80, 8'h80, "R5");
        apply(1, 8'h00, 8'h7F, "R6");
        apply(1, 8'hB0, 8'h00, "R6");
        apply(1, 8'h7F, 8'h7F, "R7");
        apply(1, 8'h7F, 8'hB0, "R7");
        apply(1, 8'h01, 8'h01, "R8");
        apply(1, 8'h01, 8'hB0, "R8");
        apply(1, 8'h41, 8'h48, "R9");   // tie, rounds up to even
        apply(1, 8'h43, 8'h48, "R9");   // tie, stays on even
        apply(1, 8'hBF, 8'h48, "R10");
        apply(1, 8'hBF, 8'hB8, "R10");
        apply(0, 8'h7F, 8'h7F, "R1");   // idle with live operands
        apply(0, 8'h00, 8'h80, "R1");

        // R11: full operand sweep with random idle gaps
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                if ($urandom % 8 == 0)
                    apply(0, NB'($urandom), NB'($urandom), "R1");
                apply(1, NB'(a), NB'(b), "R11");
            end
        end
        apply(0, 8'h00, 8'h00, "R1");
        @(negedge clk);
        verify();

        done = 1'b1;
        report();
        $finish;
    end

endmodule